// File: doc/BRIEF.md
# Segmented Paging Address Translator

This block turns a 15-bit logical address into a 15-bit physical address. It uses two lookups. The top two address bits pick one of four segments in a small on-chip segment table. Each table entry gives a length limit and the base of that segment's page table. The remaining 13 bits are the segment-relative offset. This offset splits into a 3-bit page index and a 10-bit byte offset within the page.

The offset is first compared against the segment limit. An offset outside the segment ends the translation at once with a limit fault, and no memory access is made. Otherwise the page-table entry address is formed by joining the page-table base (upper bits) to the page index (lower bits). That entry is fetched over a request/valid read port, and the read may take any number of cycles. The fetched entry carries a valid flag and a 5-bit frame number. A valid entry yields the frame number placed above the byte offset. An invalid entry yields a page fault.

Translations are accepted one at a time. The segment table is loaded through a simple write port.

Top module: `segpage_xlate`

## Requirements
- R1: After synchronous reset, `req_ready` is 1 and `rsp_valid` and `pt_rd_req` are 0. Every segment-table entry resets to limit 0 and base 0.
- R2: A cycle with `st_wr_en` high stores `st_wr_limit` and `st_wr_base` into entry `st_wr_idx`. Translations that start afterwards use the new values.
- R3: The 13-bit segment offset (logical bits [12:0]) is valid when it is strictly less than the 14-bit limit. If it is not, the response has `rsp_limit_fault`=1 and `rsp_paddr`=0, and `pt_rd_req` never rises for that translation. This check takes priority over any page-table content.
- R4: For an in-range offset, `pt_rd_addr` equals {page-table base (7 bits), page index (logical bits [12:10])}.
- R5: `pt_rd_req` stays high with a stable `pt_rd_addr` from the cycle after the limit check until the cycle in which `pt_rd_valid` is seen. Any read latency is accepted.
- R6: A page-table entry is `pt_rd_data`, with bit 5 as the valid flag and bits [4:0] as the frame number. An entry with bit 5 clear gives `rsp_page_fault`=1 and `rsp_paddr`=0. The limit fault and the page fault never appear together.
- R7: For a valid entry, `rsp_paddr` = {frame (bits [14:10]), byte offset (logical bits [9:0])} and both fault flags are 0.
- R8: `rsp_valid` is a single-cycle pulse per accepted request. `req_ready` is 1 only while idle. `req_valid` presented while busy is ignored: it neither alters the response in flight nor starts another translation.
- R9: Limit boundaries are exact. An offset equal to limit-1 translates, an offset equal to the limit faults, and a limit of 0 faults every offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_wr_en | input | 1 | Segment-table write strobe |
| st_wr_idx | input | 2 | Segment-table entry to write |
| st_wr_limit | input | 14 | Segment length written |
| st_wr_base | input | 7 | Page-table base written |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Idle, request will be taken |
| req_laddr | input | 15 | Logical address {segment, page, byte offset} |
| pt_rd_req | output | 1 | Page-table read request, held until data |
| pt_rd_addr | output | 10 | Page-table entry address |
| pt_rd_valid | input | 1 | Read data valid |
| pt_rd_data | input | 6 | Page-table entry {valid, frame} |
| rsp_valid | output | 1 | Translation result pulse |
| rsp_paddr | output | 15 | Physical address |
| rsp_limit_fault | output | 1 | Offset outside segment |
| rsp_page_fault | output | 1 | Page-table entry not valid |

## Verification
The assertions assume the memory side pulses `pt_rd_valid` only while `pt_rd_req` is high. They also assume `pt_rd_data` is meaningful in that cycle, and that the segment table is not rewritten while a translation is in flight. The bench keeps to these assumptions:
- Its memory model answers exactly once per observed request, after a chosen latency of 0 to 12 cycles.
- It drives the data only together with valid.
- It loads the segment table only while the block is idle.

// File: rtl/segpage_pkg.sv
package segpage_pkg;
    localparam int SEG_W   = 2;
    localparam int PAGE_W  = 3;
    localparam int OFF_W   = 10;
    localparam int FRAME_W = 5;
    localparam int PTB_W   = 7;

    localparam int VOFF_W  = PAGE_W + OFF_W;
    localparam int LIM_W   = VOFF_W + 1;
    localparam int LA_W    = SEG_W + VOFF_W;
    localparam int PA_W    = FRAME_W + OFF_W;
    localparam int PTA_W   = PTB_W + PAGE_W;
    localparam int PTE_W   = FRAME_W + 1;
    localparam int NSEG    = 1 << SEG_W;

    typedef struct packed {
        logic [LIM_W-1:0] limit;
        logic [PTB_W-1:0] pt_base;
    } seg_entry_t;

    typedef struct packed {
        logic               valid;
        logic [FRAME_W-1:0] frame;
    } pte_t;

    typedef struct packed {
        logic [SEG_W-1:0]  seg;
        logic [PAGE_W-1:0] page;
        logic [OFF_W-1:0]  off;
    } laddr_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_WAIT,
        ST_DONE
    } xstate_t;

    function automatic logic offset_in_range(logic [VOFF_W-1:0] voff,
                                             logic [LIM_W-1:0]  lim);
        return {1'b0, voff} < lim;
    endfunction

    function automatic logic [PTA_W-1:0] make_pte_addr(logic [PTB_W-1:0]  base,
                                                       logic [PAGE_W-1:0] page);
        return {base, page};
    endfunction
endpackage

// File: rtl/segpage_seg_table.sv
module segpage_seg_table
    import segpage_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEG_W-1:0] wr_idx,
    input  seg_entry_t       wr_entry,
    input  logic [SEG_W-1:0] rd_idx,
    output seg_entry_t       rd_entry
);
    seg_entry_t ent [NSEG];

    for (genvar g = 0; g < NSEG; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                ent[g] <= '0;
            end else if (wr_en && (wr_idx == SEG_W'(g))) begin
                ent[g] <= wr_entry;
            end
        end
    end

    assign rd_entry = ent[rd_idx];

    // R2: a write lands in the addressed entry on the next cycle
    assert_table_write_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (ent[$past(wr_idx)] == $past(wr_entry)));
endmodule

// File: rtl/segpage_xlate_ctrl.sv
module segpage_xlate_ctrl
    import segpage_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  laddr_t           req_laddr,
    output logic [SEG_W-1:0] seg_idx,
    input  seg_entry_t       seg_entry,
    output logic             pt_rd_req,
    output logic [PTA_W-1:0] pt_rd_addr,
    input  logic             pt_rd_valid,
    input  pte_t             pte_in,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             rsp_limit_fault,
    output logic             rsp_page_fault
);
    xstate_t          state;
    laddr_t           la_q;
    logic [PTA_W-1:0] pta_q;
    logic [PA_W-1:0]  paddr_q;
    logic             lf_q;
    logic             pf_q;
    logic             in_range;

    assign seg_idx  = la_q.seg;
    assign in_range = offset_in_range({la_q.page, la_q.off}, seg_entry.limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            la_q    <= '0;
            pta_q   <= '0;
            paddr_q <= '0;
            lf_q    <= 1'b0;
            pf_q    <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        la_q    <= req_laddr;
                        paddr_q <= '0;
                        lf_q    <= 1'b0;
                        pf_q    <= 1'b0;
                        state   <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (!in_range) begin
                        lf_q  <= 1'b1;
                        state <= ST_DONE;
                    end else begin
                        pta_q <= make_pte_addr(seg_entry.pt_base, la_q.page);
                        state <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (pt_rd_valid) begin
                        if (pte_in.valid) begin
                            paddr_q <= {pte_in.frame, la_q.off};
                        end else begin
                            pf_q <= 1'b1;
                        end
                        state <= ST_DONE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign req_ready       = (state == ST_IDLE);
    assign pt_rd_req       = (state == ST_WAIT);
    assign pt_rd_addr      = pta_q;
    assign rsp_valid       = (state == ST_DONE);
    assign rsp_paddr       = paddr_q;
    assign rsp_limit_fault = lf_q;
    assign rsp_page_fault  = pf_q;

    // R5: an unanswered read keeps its request and address
    assert_read_held_R5: assert property (@(posedge clk) disable iff (rst)
        (pt_rd_req && !pt_rd_valid) |=> (pt_rd_req && $stable(pt_rd_addr)));

    // R3: a limit fault is decided in the check step, never after a read
    assert_no_read_on_limit_fault_R3: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_limit_fault) |-> !$past(pt_rd_req));

    // R6: the two fault kinds are exclusive
    assert_faults_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !(rsp_limit_fault && rsp_page_fault));

    // R7: a faulting response carries a zero address
    assert_fault_zero_addr_R7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && (rsp_limit_fault || rsp_page_fault)) |-> (rsp_paddr == '0));

    // R8: the response is a one-cycle pulse followed by idle
    assert_rsp_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> (!rsp_valid && req_ready));

    // R8: busy means no acceptance and no read while idle
    assert_ready_idle_R8: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!pt_rd_req && !rsp_valid));
endmodule

// File: rtl/segpage_xlate.sv
module segpage_xlate
    import segpage_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             st_wr_en,
    input  logic [SEG_W-1:0] st_wr_idx,
    input  logic [LIM_W-1:0] st_wr_limit,
    input  logic [PTB_W-1:0] st_wr_base,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [LA_W-1:0]  req_laddr,
    output logic             pt_rd_req,
    output logic [PTA_W-1:0] pt_rd_addr,
    input  logic             pt_rd_valid,
    input  logic [PTE_W-1:0] pt_rd_data,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             rsp_limit_fault,
    output logic             rsp_page_fault
);
    seg_entry_t       wr_entry;
    seg_entry_t       rd_entry;
    logic [SEG_W-1:0] seg_idx;
    laddr_t           laddr;
    pte_t             pte_in;

    assign wr_entry = '{limit: st_wr_limit, pt_base: st_wr_base};
    assign laddr    = laddr_t'(req_laddr);
    assign pte_in   = pte_t'(pt_rd_data);

    segpage_seg_table u_table (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (st_wr_en),
        .wr_idx   (st_wr_idx),
        .wr_entry (wr_entry),
        .rd_idx   (seg_idx),
        .rd_entry (rd_entry)
    );

    segpage_xlate_ctrl u_ctrl (
        .clk             (clk),
        .rst             (rst),
        .req_valid       (req_valid),
        .req_ready       (req_ready),
        .req_laddr       (laddr),
        .seg_idx         (seg_idx),
        .seg_entry       (rd_entry),
        .pt_rd_req       (pt_rd_req),
        .pt_rd_addr      (pt_rd_addr),
        .pt_rd_valid     (pt_rd_valid),
        .pte_in          (pte_in),
        .rsp_valid       (rsp_valid),
        .rsp_paddr       (rsp_paddr),
        .rsp_limit_fault (rsp_limit_fault),
        .rsp_page_fault  (rsp_page_fault)
    );
endmodule

// File: tb/segpage_xlate_tb_top.sv
module segpage_xlate_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        st_wr_en = 1'b0;
    logic [1:0]  st_wr_idx = '0;
    logic [13:0] st_wr_limit = '0;
    logic [6:0]  st_wr_base = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [14:0] req_laddr = '0;
    logic        pt_rd_req;
    logic [9:0]  pt_rd_addr;
    logic        pt_rd_valid = 1'b0;
    logic [5:0]  pt_rd_data = '0;
    logic        rsp_valid;
    logic [14:0] rsp_paddr;
    logic        rsp_limit_fault;
    logic        rsp_page_fault;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit finished = 1'b0;

    int tb_lim  [4];
    int tb_base [4];

    always #2 clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    segpage_xlate dut_i (.*);

    localparam int NV = 11;
    localparam logic [14:0] VLA [NV] = '{
        {2'd0, 3'd0, 10'd0},
        {2'd0, 3'd5, 10'd1023},
        {2'd0, 3'd6, 10'd5},
        {2'd0, 3'd7, 10'd1023},
        {2'd1, 3'd1, 10'd475},
        {2'd1, 3'd1, 10'd476},
        {2'd2, 3'd0, 10'd0},
        {2'd3, 3'd2, 10'd1023},
        {2'd3, 3'd3, 10'd0},
        {2'd3, 3'd6, 10'd9},
        {2'd1, 3'd0, 10'd100}
    };
    localparam int VLAT [NV] = '{0, 3, 1, 7, 2, 0, 0, 4, 0, 0, 12};

    function automatic logic [5:0] pte_of(logic [9:0] a);
        logic [5:0] r;
        r[5]   = (a[2:0] != 3'd6);
        r[4:0] = a[4:0] ^ a[9:5];
        return r;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic load_seg(int idx, int lim, int base);
        @(negedge clk);
        st_wr_en    = 1'b1;
        st_wr_idx   = 2'(idx);
        st_wr_limit = 14'(lim);
        st_wr_base  = 7'(base);
        tb_lim[idx]  = lim;
        tb_base[idx] = base;
        @(negedge clk);
        st_wr_en = 1'b0;
    endtask

    // Drives one translation, serves its page-table read after lat cycles,
    // and checks the response against the model. intrude drives a second
    // request while busy.
    task automatic run_xlate(logic [14:0] la, int lat, bit intrude);
        int seg, page, off, voff;
        bit exp_lf, exp_pf;
        int exp_pa, exp_addr;
        logic [5:0] pte;
        bit saw, served, got, unstable, busy_ok;
        int held, first_addr;
        seg  = int'(la[14:13]);
        page = int'(la[12:10]);
        off  = int'(la[9:0]);
        voff = int'(la[12:0]);
        exp_addr = tb_base[seg] * 8 + page;
        exp_lf = (voff >= tb_lim[seg]);
        pte = pte_of(10'(exp_addr));
        exp_pf = !exp_lf && !pte[5];
        exp_pa = (exp_lf || exp_pf) ? 0 : int'(pte[4:0]) * 1024 + off;

        @(negedge clk);
        req_valid = 1'b1;
        req_laddr = la;
        @(negedge clk);
        req_valid = 1'b0;
        saw = 0; served = 0; got = 0; unstable = 0; held = 0;
        first_addr = 0; busy_ok = 1;
        for (int i = 0; i < 60; i++) begin
            if (intrude && i > 0) begin
                req_valid = 1'b1;
                req_laddr = {2'd0, 3'd5, 10'd7};
                if (req_ready) busy_ok = 0;
            end
            if (rsp_valid) begin
                got = 1;
                req_valid = 1'b0;
                break;
            end
            if (pt_rd_req && !served) begin
                if (!saw) first_addr = int'(pt_rd_addr);
                else if (int'(pt_rd_addr) != first_addr) unstable = 1;
                saw = 1;
                if (held == lat) begin
                    pt_rd_valid = 1'b1;
                    pt_rd_data  = pte_of(pt_rd_addr);
                    served = 1;
                end
                held++;
            end
            @(negedge clk);
            pt_rd_valid = 1'b0;
            pt_rd_data  = '0;
        end
        req_valid = 1'b0;

        check(got, "R8", "response seen", int'(got), 1);
        if (exp_lf) begin
            check(!saw, "R3", "read issued on limit fault", int'(saw), 0);
        end else begin
            check(saw && first_addr == exp_addr, "R4", "pte address",
                  first_addr, exp_addr);
            check(!unstable && held == lat + 1, "R5", "read held cycles",
                  held, lat + 1);
        end
        check(rsp_limit_fault == exp_lf, "R3", "limit fault",
              int'(rsp_limit_fault), int'(exp_lf));
        check(rsp_page_fault == exp_pf, "R6", "page fault",
              int'(rsp_page_fault), int'(exp_pf));
        check(int'(rsp_paddr) == exp_pa, "R7", "physical address",
              int'(rsp_paddr), exp_pa);
        if (intrude) check(busy_ok, "R8", "ready while busy", 1, 0);
        @(negedge clk);
        check(!rsp_valid && req_ready && !pt_rd_req, "R8", "pulse then idle",
              int'(rsp_valid), 0);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state at the ports
        check(req_ready && !rsp_valid && !pt_rd_req, "R1", "reset outputs",
              int'({req_ready, rsp_valid, pt_rd_req}), 4);
        // R1: reset table has limit 0, so segment 0 faults at offset 0
        tb_lim  = '{0, 0, 0, 0};
        tb_base = '{0, 0, 0, 0};
        run_xlate({2'd0, 3'd0, 10'd0}, 0, 0);

        load_seg(0, 8192, 7'h05);
        load_seg(1, 1500, 7'h12);
        load_seg(2, 0,    7'h40);
        load_seg(3, 3072, 7'h7F);

        // Table walk: R3 R4 R5 R6 R7 and R9 boundaries (1499 ok, 1500 and
        // 3072 fault, limit 0 faults, limit fault before an invalid entry)
        for (int v = 0; v < NV; v++) begin
            run_xlate(VLA[v], VLAT[v], 0);
        end

        // R8: a request while busy is ignored
        run_xlate({2'd1, 3'd0, 10'd200}, 5, 1);

        // R2: rewriting segment 2 makes a previously faulting offset translate
        load_seg(2, 2000, 7'h33);
        run_xlate({2'd2, 3'd1, 10'd3}, 2, 0);
        // R9: new limit boundary exactly
        run_xlate({2'd2, 3'd1, 10'd975}, 1, 0);
        run_xlate({2'd2, 3'd1, 10'd976}, 0, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        wait (cycles >= 20000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule